// File: doc/BRIEF.md
# Rolling Shutter Line Timing Controller

This block paces the row-by-row scan of a line-scan imager that uses an electronic shutter. It drives two row pointers. The read pointer selects the line whose charge is being converted. The reset pointer selects the line being cleared. Both pointers step together. The reset pointer is placed a programmable number of lines ahead of the read pointer, so the exposure of every line is that line distance multiplied by the line period. The line period is the blanking cycles plus the pixel count, counted in pixel clocks.

Each frame begins with a one-cycle sync pulse. On the following edge, the read pointer loads the window start row and the reset pointer loads that row plus the offset, modulo the row count. Every line then runs a blanking gap with no strobe, followed by one pixel-valid strobe per pixel. In the last pixel cycle of a line, both advance pulses fire together. In the last pixel cycle of the last windowed line, a frame-done pulse fires in place of the advance pulses, and the next cycle starts a new frame with a fresh sync. Frames repeat for as long as reset stays high.

Top module: `rs_line_timer`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, both row outputs are 0, both sync outputs are 1, and pix_valid, the advance outputs and frame_done are 0.
- R2: Each frame opens with exactly one cycle in which rd_sync and rst_sync are both 1. On the next clock edge rd_row takes the value of win_start.
- R3: On that same edge rst_row takes (win_start + offset) modulo ROWS, where an offset input of 0 is treated as 1.
- R4: Every line consists of blank_cycles cycles with all strobes low, followed by max(pix_per_line, 1) consecutive cycles with pix_valid = 1. A blank_cycles value of 0 leaves no gap.
- R5: In the last pix_valid cycle of every line except the last line of the window, rd_adv and rst_adv are both 1. On the next edge each row output increments by one and wraps from ROWS-1 to 0.
- R6: Within a frame, the distance (rst_row - rd_row) modulo ROWS stays equal to the effective offset.
- R7: The window holds max(win_height, 1) lines. frame_done is 1 only in the last pix_valid cycle of the last line, and the cycle after it is a sync cycle.
- R8: Sync, advance and frame_done never occur in the same cycle, and pix_valid is never 1 during a sync cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_start | input | 8 | First row of the vertical window |
| win_height | input | 9 | Number of lines in the window (0 is treated as 1) |
| pix_per_line | input | 12 | Pixel strobes per line (0 is treated as 1) |
| line_offset | input | 8 | Line distance from the read pointer to the reset pointer (0 is treated as 1) |
| blank_cycles | input | 8 | Blanking cycles at the start of each line |
| rd_sync | output | 1 | Frame sync pulse for the read pointer |
| rst_sync | output | 1 | Frame sync pulse for the reset pointer |
| rd_adv | output | 1 | Advance pulse for the read pointer |
| rst_adv | output | 1 | Advance pulse for the reset pointer |
| pix_valid | output | 1 | One strobe per pixel clock while pixels are read out |
| frame_done | output | 1 | Marks the last pixel of the last windowed line |
| rd_row | output | 8 | Current read row |
| rst_row | output | 8 | Current reset row |

## Verification
The last pixel strobe of a line always shares its cycle with either the advance pulse pair or frame_done. Row wraparound can also coincide with an advance. One case puts the window start near the top row, so the read pointer wraps in the middle of a frame. Another uses a large offset, so the reset pointer's load row already lies past the wrap point. The behavioural model predicts for every cycle whether pix_valid, the advance pair and frame_done are set and which rows are shown. It flags any cycle where an advance appears without the matching pixel strobe, or where a frame_done appears together with an advance.

// File: rtl/rs_timing_pkg.sv
package rs_timing_pkg;
    typedef enum logic [1:0] {
        PH_SYNC  = 2'd0,
        PH_BLANK = 2'd1,
        PH_PIXEL = 2'd2
    } phase_e;
endpackage

// File: rtl/rs_row_pointer.sv
module rs_row_pointer #(
    parameter int ROWS  = 256,
    parameter int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ROW_W-1:0] load_row,
    input  logic             step,
    output logic [ROW_W-1:0] row
);
    localparam logic [ROW_W-1:0] TOP_ROW = ROW_W'(ROWS - 1);

    logic [ROW_W-1:0] row_d, row_q;

    always_comb begin
        row_d = row_q;
        if (load) begin
            row_d = load_row;
        end else if (step) begin
            row_d = (row_q == TOP_ROW) ? '0 : row_q + ROW_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
    end

    assign row = row_q;

    // R5: a step always moves the pointer
    a_r5_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (row_q != $past(row_q)));
endmodule

// File: rtl/rs_line_sequencer.sv
module rs_line_sequencer
    import rs_timing_pkg::*;
#(
    parameter int ROW_W   = 8,
    parameter int PIX_W   = 12,
    parameter int BLANK_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ROW_W:0]     height,
    input  logic [PIX_W-1:0]   pix_count,
    input  logic [BLANK_W-1:0] blank,
    output logic               frame_sync,
    output logic               pix_valid,
    output logic               line_adv,
    output logic               frame_done
);
    localparam int CNT_W = (PIX_W > BLANK_W) ? PIX_W : BLANK_W;

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [ROW_W:0]   line;
    } seq_s;

    seq_s             seq_d, seq_q;
    logic [PIX_W-1:0] pix_eff;
    logic [ROW_W:0]   h_eff;
    logic [CNT_W-1:0] pix_last, blank_last;
    logic             line_end, last_line;
    phase_e           line_first_ph;

    always_comb begin
        pix_eff       = (pix_count == '0) ? PIX_W'(1) : pix_count;
        h_eff         = (height == '0) ? (ROW_W+1)'(1) : height;
        pix_last      = CNT_W'(pix_eff) - CNT_W'(1);
        blank_last    = CNT_W'(blank) - CNT_W'(1);
        line_first_ph = (blank == '0) ? PH_PIXEL : PH_BLANK;
        line_end      = (seq_q.ph == PH_PIXEL) && (seq_q.cnt == pix_last);
        last_line     = (seq_q.line == h_eff - (ROW_W+1)'(1));

        seq_d = seq_q;
        unique case (seq_q.ph)
            PH_SYNC: begin
                seq_d.line = '0;
                seq_d.cnt  = '0;
                seq_d.ph   = line_first_ph;
            end
            PH_BLANK: begin
                if (seq_q.cnt == blank_last) begin
                    seq_d.cnt = '0;
                    seq_d.ph  = PH_PIXEL;
                end else begin
                    seq_d.cnt = seq_q.cnt + CNT_W'(1);
                end
            end
            PH_PIXEL: begin
                if (line_end) begin
                    seq_d.cnt = '0;
                    if (last_line) begin
                        seq_d.ph = PH_SYNC;
                    end else begin
                        seq_d.line = seq_q.line + (ROW_W+1)'(1);
                        seq_d.ph   = line_first_ph;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt + CNT_W'(1);
                end
            end
            default: seq_d.ph = PH_SYNC;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.ph   <= PH_SYNC;
            seq_q.cnt  <= '0;
            seq_q.line <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign frame_sync = (seq_q.ph == PH_SYNC);
    assign pix_valid  = (seq_q.ph == PH_PIXEL);
    assign line_adv   = line_end && !last_line;
    assign frame_done = line_end && last_line;

    // R8: the frame events never overlap
    a_r8_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_sync, line_adv, frame_done}));
    // R8: no pixel strobe in a sync cycle
    a_r8_no_pix_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |-> !pix_valid);
    // R7: a new frame follows frame done
    a_r7_done_then_sync: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> frame_sync);
    // R5: an advance sits on a pixel strobe
    a_r5_adv_on_pixel: assert property (@(posedge clk) disable iff (!rst_n)
        line_adv |-> pix_valid);
endmodule

// File: rtl/rs_line_timer.sv
module rs_line_timer #(
    parameter int ROWS    = 256,
    parameter int PIX_W   = 12,
    parameter int BLANK_W = 8,
    localparam int ROW_W  = $clog2(ROWS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ROW_W-1:0]   win_start,
    input  logic [ROW_W:0]     win_height,
    input  logic [PIX_W-1:0]   pix_per_line,
    input  logic [ROW_W-1:0]   line_offset,
    input  logic [BLANK_W-1:0] blank_cycles,
    output logic               rd_sync,
    output logic               rst_sync,
    output logic               rd_adv,
    output logic               rst_adv,
    output logic               pix_valid,
    output logic               frame_done,
    output logic [ROW_W-1:0]   rd_row,
    output logic [ROW_W-1:0]   rst_row
);
    localparam logic [ROW_W:0] ROWS_X = (ROW_W+1)'(ROWS);

    logic             frame_sync, line_adv;
    logic [ROW_W:0]   off_eff, start_sum, rst_start, row_gap;
    logic [ROW_W-1:0] load_rows [2];
    logic [ROW_W-1:0] rows      [2];

    always_comb begin
        off_eff   = (line_offset == '0) ? (ROW_W+1)'(1) : {1'b0, line_offset};
        start_sum = {1'b0, win_start} + off_eff;
        rst_start = (start_sum >= ROWS_X) ? start_sum - ROWS_X : start_sum;
        load_rows[0] = win_start;
        load_rows[1] = rst_start[ROW_W-1:0];
        row_gap = (rows[1] >= rows[0])
                ? {1'b0, rows[1]} - {1'b0, rows[0]}
                : {1'b0, rows[1]} + ROWS_X - {1'b0, rows[0]};
    end

    rs_line_sequencer #(
        .ROW_W  (ROW_W),
        .PIX_W  (PIX_W),
        .BLANK_W(BLANK_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .height    (win_height),
        .pix_count (pix_per_line),
        .blank     (blank_cycles),
        .frame_sync(frame_sync),
        .pix_valid (pix_valid),
        .line_adv  (line_adv),
        .frame_done(frame_done)
    );

    for (genvar g = 0; g < 2; g++) begin : g_ptr
        rs_row_pointer #(
            .ROWS (ROWS),
            .ROW_W(ROW_W)
        ) u_ptr (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (frame_sync),
            .load_row(load_rows[g]),
            .step    (line_adv),
            .row     (rows[g])
        );
    end

    assign rd_sync  = frame_sync;
    assign rst_sync = frame_sync;
    assign rd_adv   = line_adv;
    assign rst_adv  = line_adv;
    assign rd_row   = rows[0];
    assign rst_row  = rows[1];

    // R2: read pointer loads the window start
    a_r2_read_load: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sync |=> (rd_row == $past(win_start)));
    // R3: reset pointer lands offset lines ahead
    a_r3_reset_load: assert property (@(posedge clk) disable iff (!rst_n)
        rst_sync |=> (row_gap == $past(off_eff)));
    // R6: advancing keeps the gap
    a_r6_gap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rd_adv |=> (row_gap == $past(row_gap)));
endmodule

// File: tb/rs_line_timer_bench.sv
module rs_line_timer_bench;
    localparam int ROWS = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  win_start = '0;
    logic [8:0]  win_height = 9'd1;
    logic [11:0] pix_per_line = 12'd1;
    logic [7:0]  line_offset = '0;
    logic [7:0]  blank_cycles = '0;
    logic        rd_sync, rst_sync, rd_adv, rst_adv, pix_valid, frame_done;
    logic [7:0]  rd_row, rst_row;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    rs_line_timer u_rs_line_timer (
        .clk(clk), .rst_n(rst_n),
        .win_start(win_start), .win_height(win_height),
        .pix_per_line(pix_per_line), .line_offset(line_offset),
        .blank_cycles(blank_cycles),
        .rd_sync(rd_sync), .rst_sync(rst_sync),
        .rd_adv(rd_adv), .rst_adv(rst_adv),
        .pix_valid(pix_valid), .frame_done(frame_done),
        .rd_row(rd_row), .rst_row(rst_row)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    task automatic cmp_cycle(input int e_sync, input int e_pv, input int e_adv,
                             input int e_done, input int e_rd, input int e_rs);
        chk(rd_sync == e_sync && rst_sync == e_sync, "R2 sync", int'(rd_sync), e_sync);
        chk(pix_valid == e_pv, "R4 pix_valid", int'(pix_valid), e_pv);
        chk(rd_adv == e_adv && rst_adv == e_adv, "R5 advance", int'(rd_adv), e_adv);
        chk(frame_done == e_done, "R7 frame_done", int'(frame_done), e_done);
        chk(rd_row == e_rd, "R2 R5 rd_row", int'(rd_row), e_rd);
        chk(rst_row == e_rs, "R3 R5 rst_row", int'(rst_row), e_rs);
        // R8: covered by the exclusive expectations above
    endtask

    task automatic next_cycle();
        @(negedge clk);
        #1;
    endtask

    task automatic run_case(input int st, input int h, input int px, input int off,
                            input int bl, input int frames);
        int he, pe, oe, e_rd, e_rs;
        rst_n = 1'b0;
        win_start = 8'(st); win_height = 9'(h); pix_per_line = 12'(px);
        line_offset = 8'(off); blank_cycles = 8'(bl);
        repeat (2) @(negedge clk);
        #1;
        // R1: state held in reset
        chk(rd_row == 0 && rst_row == 0, "R1 rows in reset", int'(rd_row), 0);
        chk(rd_sync == 1 && pix_valid == 0 && rd_adv == 0 && frame_done == 0,
            "R1 strobes in reset", int'(pix_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        he = (h == 0) ? 1 : h;
        pe = (px == 0) ? 1 : px;
        oe = (off == 0) ? 1 : off;
        e_rd = 0; e_rs = 0;
        for (int f = 0; f < frames; f++) begin
            cmp_cycle(1, 0, 0, 0, e_rd, e_rs);
            e_rd = st;
            e_rs = (st + oe) % ROWS;
            next_cycle();
            for (int l = 0; l < he; l++) begin
                for (int b = 0; b < bl; b++) begin
                    cmp_cycle(0, 0, 0, 0, e_rd, e_rs);
                    next_cycle();
                end
                for (int p = 0; p < pe; p++) begin
                    bit last_px = (p == pe - 1);
                    bit last_ln = (l == he - 1);
                    cmp_cycle(0, 1, int'(last_px && !last_ln), int'(last_px && last_ln),
                              e_rd, e_rs);
                    if (last_px) begin
                        // R6: gap seen at the ports stays at the offset
                        chk(((int'(rst_row) - int'(rd_row) + ROWS) % ROWS) == oe,
                            "R6 row gap", (int'(rst_row) - int'(rd_row) + ROWS) % ROWS, oe);
                    end
                    next_cycle();
                    if (last_px && !last_ln) begin
                        e_rd = (e_rd + 1) % ROWS;
                        e_rs = (e_rs + 1) % ROWS;
                    end
                end
            end
        end
    endtask

    initial begin
        run_case(10, 4, 5, 3, 2, 2);      // R4 R5 basic window
        run_case(250, 8, 1, 0, 0, 2);     // R3 zero offset, R5 read wrap, R4 no gap
        run_case(200, 3, 7, 255, 4, 2);   // R3 reset start wraps
        run_case(0, 3, 20, 5, 26, 1);     // R4 typical blanking
        run_case(5, 0, 0, 1, 1, 3);       // R7 height 0 and pixels 0 as 1
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R7 watchdog: actual %0d cycles expected completion", 150000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule